// File: doc/BRIEF.md
# Batch ALU Job Sequencer

This block runs a batch of arithmetic and logic jobs out of its own 256-word by 32-bit memory. A testbench or host first loads the memory through a write port. The host loads operand pairs into the low region, opcodes into a middle region and, optionally, a stop word. After reset is released, the engine walks through the jobs using a single job counter. For each job it reads the opcode and then the two operands. It evaluates them in a combinational seven-operation ALU and stores the result in the high region.

The run ends in one of two ways. The engine may read an opcode word of all ones, or it may finish the largest number of jobs whose operands stay below the opcode region. After that the engine parks in a terminal state and raises `done`. The host can then read the results back through a registered read port. The memory keeps its contents through reset, so the host can preload while reset is held and inspect after a run.

Top module: `batch_alu_seq`

## Requirements
- R1: For job i, operand A is read from address 2*i and operand B from address 2*i+1.
- R2: The opcode of job i is read from address 100+i, and its result is written to address 200+i.
- R3: Opcode values are 0 = zero result, 1 = B+A, 2 = B−A, 3 = A AND B, 4 = A OR B, 5 = A XOR B, 6 = NOR of A and B. Any other 32-bit value except all ones yields 0.
- R4: Add and subtract wrap modulo 2^32.
- R5: An opcode word of 0xFFFFFFFF stops the run without any write. The terminal state holds `done` high until reset.
- R6: Each job takes exactly four clock cycles. With N jobs before the stop word, `done` is first seen high after 4*N+2 rising edges following reset release.
- R7: While reset is low, `busy` and `done` are both 0. After release, `busy` is 1 until the terminal state is reached, then `busy` is 0 and `done` is 1.
- R8: A host write (`host_we`) takes effect only while reset is low or `done` is high. It is ignored while `busy` is high.
- R9: Reset returns the job counter and state to the start but leaves memory untouched. `host_rdata` shows the word at `host_addr` one cycle after the address is applied.
- R10: Without a stop word, the run ends after 50 jobs (addresses 200..249 written) in 200 cycles, and raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 8 | Host write/read address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| busy | output | 1 | Engine is running jobs |
| done | output | 1 | Engine has stopped |

## Verification
The completion flag is due 4*N+2 rising edges after reset release for a run of N jobs, and 200 edges for a run that ends at the job limit. The bench therefore counts falling edges from release until `done` is seen and compares that count exactly. Results are read only after `done`, through the read port, and each value is sampled on the falling edge after the one on which its address was applied. Writes attempted during a run are judged by the results and memory words they would have changed, once the run has finished.

// File: rtl/batch_alu_seq.sv
module batch_alu_seq #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int OP_BASE  = 100,
  parameter int RES_BASE = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              done
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MAX_JOBS = OP_BASE / 2;
  localparam int JW       = $clog2(MAX_JOBS + 1);

  typedef enum logic [2:0] {S_OP, S_A, S_B, S_WB, S_DONE} st_t;

  st_t               state;
  logic [JW-1:0]     job;
  logic [DATA_W-1:0] opc, opa, rd_data, alu_y;
  logic [ADDR_W-1:0] rd_addr, res_addr;
  logic [DATA_W-1:0] mem [DEPTH];

  wire eng_we   = (state == S_WB);
  wire host_ok  = host_we && (!rst_n || state == S_DONE);
  wire stop_op  = &rd_data;
  wire last_job = (job == JW'(MAX_JOBS - 1));

  assign done     = (state == S_DONE);
  assign busy     = rst_n && !done;
  assign res_addr = ADDR_W'(RES_BASE) + ADDR_W'(job);

  always_comb begin
    case (state)
      S_OP:    rd_addr = ADDR_W'(OP_BASE) + ADDR_W'(job);
      S_A:     rd_addr = ADDR_W'({job, 1'b0});
      S_B:     rd_addr = ADDR_W'({job, 1'b1});
      default: rd_addr = '0;
    endcase
  end

  always_comb begin
    case (opc)
      DATA_W'(1): alu_y = rd_data + opa;
      DATA_W'(2): alu_y = rd_data - opa;
      DATA_W'(3): alu_y = opa & rd_data;
      DATA_W'(4): alu_y = opa | rd_data;
      DATA_W'(5): alu_y = opa ^ rd_data;
      DATA_W'(6): alu_y = ~(opa | rd_data);
      default:    alu_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (eng_we)       mem[res_addr] <= alu_y;
    else if (host_ok) mem[host_addr] <= host_wdata;
    rd_data    <= mem[rd_addr];
    host_rdata <= mem[host_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OP;
      job   <= '0;
      opc   <= '0;
      opa   <= '0;
    end else begin
      case (state)
        S_OP: state <= S_A;
        S_A: begin
          opc   <= rd_data;
          state <= stop_op ? S_DONE : S_B;
        end
        S_B: begin
          opa   <= rd_data;
          state <= S_WB;
        end
        S_WB: begin
          job   <= job + 1'b1;
          state <= last_job ? S_DONE : S_OP;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_stop_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_A && stop_op) |=> (done && !busy));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy != done);

  p_job_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && !last_job) |=> (state == S_OP && job == $past(job) + 1'b1));

  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_B) |-> ($past(state) == S_A));

  p_job_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    job <= JW'(MAX_JOBS));
endmodule

// File: tb/batch_alu_seq_bench.sv
module batch_alu_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_we = 0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, done;
  int checks = 0, errors = 0, cyc = 0;
  localparam logic [31:0] SENT = 32'h5555_5555;

  always #4 clk = ~clk;

  batch_alu_seq u_batch_alu_seq (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog: cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic go(output int n);
    @(negedge clk);
    rst_n = 1;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R7 busy after release", {31'b0, busy}, 32'd1);
    end
  endtask

  task automatic load_example();
    rst_n = 0;
    for (int i = 0; i < 14; i++) hwrite(8'(i), 32'(10 + i));
    for (int i = 0; i < 7; i++) hwrite(8'(100 + i), 32'(i));
    hwrite(8'd107, 32'hFFFF_FFFF);
    for (int i = 200; i < 208; i++) hwrite(8'(i), SENT);
    hwrite(8'd250, SENT);
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk);
    chk("R7 busy in reset", {31'b0, busy}, 32'd0);
    chk("R7 done in reset", {31'b0, done}, 32'd0);
  endtask

  task automatic t_example();
    int n; logic [31:0] d;
    logic [31:0] exp [7] = '{32'd0, 32'd25, 32'd1, 32'd16, 32'd19, 32'd1, 32'hFFFF_FFE8};
    load_example();
    go(n);
    chk("R6 cycles for 7 jobs", 32'(n), 32'd30);
    for (int i = 0; i < 7; i++) begin
      hread(8'(200 + i), d);
      chk("R1 R2 R3 result", d, exp[i]);
    end
    hread(8'd207, d);
    chk("R5 no write on stop", d, SENT);
    repeat (5) @(negedge clk);
    chk("R5 done held", {31'b0, done}, 32'd1);
    chk("R7 busy low when done", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_host_ignore();
    int n; logic [31:0] d;
    load_example();
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    hwrite(8'd13, 32'd99);
    hwrite(8'd250, 32'd77);
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    hread(8'd206, d);
    chk("R8 operand write ignored while busy", d, 32'hFFFF_FFE8);
    hread(8'd250, d);
    chk("R8 write ignored while busy", d, SENT);
    hwrite(8'd250, 32'h1234);
    hread(8'd250, d);
    chk("R8 write honoured when done", d, 32'h1234);
  endtask

  task automatic t_reset_keeps();
    int n; logic [31:0] d;
    rst_n = 0;
    hread(8'd206, d);
    chk("R9 result kept in reset", d, 32'hFFFF_FFE8);
    hread(8'd0, d);
    chk("R9 operand kept in reset", d, 32'd10);
    @(negedge clk); rst_n = 1;
    repeat (9) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R7 busy cleared by reset", {31'b0, busy}, 32'd0);
    hwrite(8'd200, 32'hAAAA);
    go(n);
    chk("R9 restart from job 0 cycles", 32'(n), 32'd30);
    hread(8'd200, d);
    chk("R9 job 0 rerun", d, 32'd0);
  endtask

  task automatic t_codes();
    int n; logic [31:0] d;
    rst_n = 0;
    hwrite(8'd0, 32'd2);  hwrite(8'd1, 32'hFFFF_FFFF);
    hwrite(8'd2, 32'd5);  hwrite(8'd3, 32'd3);
    for (int i = 4; i < 10; i++) hwrite(8'(i), 32'd9);
    hwrite(8'd100, 32'd1); hwrite(8'd101, 32'd2); hwrite(8'd102, 32'd7);
    hwrite(8'd103, 32'h8000_0000); hwrite(8'd104, 32'hFFFF_FFFE);
    hwrite(8'd105, 32'hFFFF_FFFF);
    for (int i = 200; i < 206; i++) hwrite(8'(i), SENT);
    go(n);
    chk("R6 cycles for 5 jobs", 32'(n), 32'd22);
    hread(8'd200, d); chk("R4 add wraps", d, 32'd1);
    hread(8'd201, d); chk("R4 sub wraps", d, 32'hFFFF_FFFE);
    hread(8'd202, d); chk("R3 opcode 7 gives 0", d, 32'd0);
    hread(8'd203, d); chk("R3 opcode 0x80000000 gives 0", d, 32'd0);
    hread(8'd204, d); chk("R3 opcode 0xFFFFFFFE gives 0", d, 32'd0);
    hread(8'd205, d); chk("R5 stop word not written", d, SENT);
  endtask

  task automatic t_first_stop();
    int n; logic [31:0] d;
    rst_n = 0;
    hwrite(8'd100, 32'hFFFF_FFFF);
    hwrite(8'd200, SENT);
    go(n);
    chk("R6 immediate stop cycles", 32'(n), 32'd2);
    hread(8'd200, d);
    chk("R5 immediate stop no write", d, SENT);
  endtask

  task automatic t_limit();
    int n; logic [31:0] d;
    rst_n = 0;
    for (int i = 0; i < 50; i++) begin
      hwrite(8'(2 * i), 32'(i));
      hwrite(8'(2 * i + 1), 32'd1);
      hwrite(8'(100 + i), 32'd1);
    end
    hwrite(8'd150, 32'hFFFF_FFFF);
    hwrite(8'd250, SENT);
    go(n);
    chk("R10 limit cycles", 32'(n), 32'd200);
    hread(8'd200, d); chk("R10 first job", d, 32'd1);
    hread(8'd249, d); chk("R10 last job", d, 32'd50);
    hread(8'd250, d); chk("R10 no job past limit", d, SENT);
    chk("R10 done at limit", {31'b0, done}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_example();
    t_host_ignore();
    t_reset_keeps();
    t_codes();
    t_first_stop();
    t_limit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule